// File: doc/BRIEF.md
# Parallel Flash Command and Toggle-Status Controller

This block models the control side of a byte-wide parallel NOR flash. It watches host write strobes, recognises the unlock sequences that start a byte program or a sector erase, and runs the operation for a fixed number of clock cycles. While an operation runs, it pulls an open-drain ready/busy line low. An erase can be suspended, so that the host can read or program bytes outside the erasing sector, and then resumed.

Host reads return a status byte instead of array data while an operation is pending. Two bits of that byte flip from one read to the next under different rules. Bit 6 flips only while a program or an erase is actually running. Bit 2 flips only for reads that fall inside the sector selected for erase. By comparing successive reads, the host can find out whether the device is busy, whether it is suspended, and which sector is being erased. The cell array is not modelled: in read mode every address returns a fixed fill value.

Top module: `flash_op_status`

## Requirements
- R1: A program command is the writes (KEY1_ADDR, 0xAA), (KEY2_ADDR, 0x55), (KEY1_ADDR, 0xA0), then any address with the data byte. `ryby_n` goes low in the cycle after the fourth write strobe rises, and stays released after the third.
- R2: A sector erase is (KEY1_ADDR, 0xAA), (KEY2_ADDR, 0x55), (KEY1_ADDR, 0x80), (KEY1_ADDR, 0xAA), (KEY2_ADDR, 0x55), then any address in the target sector with 0x30. `ryby_n` goes low after the sixth write and not after the fifth.
- R3: While a program or an erase is running, every write is ignored except the suspend code 0xB0, which acts only during an erase.
- R4: Writing 0xB0 during an erase suspends it and releases `ryby_n`. Writing 0x30 to any address while suspended resumes the erase and drives `ryby_n` low again.
- R5: While `rst_n` is low, `ryby_n` is driven low. Reset aborts any operation and returns the block to read mode with both toggle bits at 0.
- R6: A program lasts PROG_LEN cycles and an erase lasts ERASE_LEN cycles of active time. After the fourth write, `ryby_n` is low for exactly PROG_LEN sampled cycles. The block then returns to read mode.
- R7: A write with the wrong address or data at any step of a sequence returns the decoder to its idle step, and no operation starts.
- R8: A status byte is {0, dq6, 000, dq2, 00} (bit 6 = dq6, bit 2 = dq2). In read mode every read returns ARRAY_FILL (0xFF). `dout` is 0 while `oe_n` is high. Toggle bits change at the rising edge of `oe_n`.
- R9: dq6 flips after each read during a normal program, a normal erase and a suspend-program. It holds its value in suspend-read mode.
- R10: During an erase, dq2 flips after a read inside the erasing sector and holds after a read outside it.
- R11: In suspend-read mode, reads inside the suspended sector return a status byte with dq2 flipping, and reads elsewhere return ARRAY_FILL.
- R12: In suspend-program mode, a read of the byte being programmed shows dq2 = 1. Reads in the suspended sector flip dq2, and other addresses show dq2 = 1. When the program completes, the block goes back to suspend-read.
- R13: `ryby_n` is open-drain. It is driven 0 or left at high impedance, never driven 1. With a pull-up, a released line reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we_n | input | 1 | Active-low write strobe; the command is taken on its rising edge |
| oe_n | input | 1 | Active-low read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte |
| ryby_n | output | 1 | Open-drain ready/busy, low = busy |

## Verification
The hardest state to reach from the ports is suspend-program inside a suspended erase. Three read rules apply at once there: the byte being programmed shows a fixed dq2, the suspended sector flips dq2, and every read flips dq6. The stimulus starts an erase, interleaves reads inside and outside the erasing sector, suspends, and issues a full program sequence. It then reads the programmed byte, the suspended sector and an unrelated sector, and checks each result against a bench-side model of both toggle bits. The bench then waits for the program to finish, confirms the block is back in suspend-read, resumes the erase and runs it to completion.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

   typedef enum logic [2:0] {
      OP_READ      = 3'd0,
      OP_PROG      = 3'd1,
      OP_ERASE     = 3'd2,
      OP_SUSP      = 3'd3,
      OP_SUSP_PROG = 3'd4
   } op_state_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_KEY1,
      SQ_KEY2,
      SQ_PGM_DATA,
      SQ_ERS_KEY0,
      SQ_ERS_KEY1,
      SQ_ERS_KEY2
   } seq_state_e;

   typedef struct packed {
      logic prog;
      logic erase;
      logic suspend;
      logic resume;
   } cmd_evt_t;

   localparam logic [7:0] CODE_KEY_A    = 8'hAA;
   localparam logic [7:0] CODE_KEY_B    = 8'h55;
   localparam logic [7:0] CODE_PROG     = 8'hA0;
   localparam logic [7:0] CODE_ERS_SET  = 8'h80;
   localparam logic [7:0] CODE_ERS_SECT = 8'h30;
   localparam logic [7:0] CODE_SUSPEND  = 8'hB0;
   localparam logic [7:0] CODE_RESUME   = 8'h30;

   function automatic logic [7:0] status_byte(input logic t6, input logic t2);
      return {1'b0, t6, 3'b000, t2, 2'b00};
   endfunction

endpackage

// File: rtl/fsc_strobe_edge.sv
module fsc_strobe_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] strobe_n,
   output logic [N-1:0] rise
);

   for (genvar i = 0; i < N; i++) begin : g_edge
      logic last_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) last_q <= 1'b1;
         else        last_q <= strobe_n[i];
      end
      assign rise[i] = strobe_n[i] & ~last_q;
   end

endmodule

// File: rtl/fsc_cmd_seq.sv
module fsc_cmd_seq
   import fsc_pkg::*;
#(
   parameter int               ADDR_W    = 18,
   parameter logic [ADDR_W-1:0] KEY1_ADDR = 'h555,
   parameter logic [ADDR_W-1:0] KEY2_ADDR = 'h2AA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  op_state_e         op_state,
   output cmd_evt_t          evt
);

   seq_state_e sq_q, sq_d;
   logic       at_k1, at_k2;

   assign at_k1 = (wr_addr == KEY1_ADDR);
   assign at_k2 = (wr_addr == KEY2_ADDR);

   always_comb begin
      sq_d = sq_q;
      evt  = '0;
      if (wr_stb) begin
         sq_d = SQ_IDLE;
         case (op_state)
            OP_ERASE: evt.suspend = (wr_data == CODE_SUSPEND);
            OP_PROG, OP_SUSP_PROG: ;
            default: begin
               case (sq_q)
                  SQ_IDLE: begin
                     if (at_k1 && wr_data == CODE_KEY_A) sq_d = SQ_KEY1;
                     else if (op_state == OP_SUSP && wr_data == CODE_RESUME) evt.resume = 1'b1;
                  end
                  SQ_KEY1: if (at_k2 && wr_data == CODE_KEY_B) sq_d = SQ_KEY2;
                  SQ_KEY2: begin
                     if (at_k1 && wr_data == CODE_PROG) sq_d = SQ_PGM_DATA;
                     else if (at_k1 && wr_data == CODE_ERS_SET && op_state == OP_READ)
                        sq_d = SQ_ERS_KEY0;
                  end
                  SQ_PGM_DATA: evt.prog = 1'b1;
                  SQ_ERS_KEY0: if (at_k1 && wr_data == CODE_KEY_A) sq_d = SQ_ERS_KEY1;
                  SQ_ERS_KEY1: if (at_k2 && wr_data == CODE_KEY_B) sq_d = SQ_ERS_KEY2;
                  SQ_ERS_KEY2: evt.erase = (wr_data == CODE_ERS_SECT);
                  default: ;
               endcase
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq_q <= SQ_IDLE;
      else        sq_q <= sq_d;
   end

endmodule

// File: rtl/fsc_op_timer.sv
module fsc_op_timer #(
   parameter int LEN = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic done
);

   localparam int CW = $clog2(LEN + 1);

   logic [CW-1:0] cnt_q;

   assign done = run && (cnt_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load)                   cnt_q <= CW'(LEN);
      else if (run && cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
   end

endmodule

// File: rtl/fsc_toggle_reg.sv
module fsc_toggle_reg
   import fsc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rd_end,
   input  op_state_e op_state,
   input  logic      in_sector,
   output logic      tog6,
   output logic      tog2
);

   logic active_op, sector_op;

   assign active_op = (op_state == OP_PROG) || (op_state == OP_ERASE) ||
                      (op_state == OP_SUSP_PROG);
   assign sector_op = (op_state == OP_ERASE) || (op_state == OP_SUSP) ||
                      (op_state == OP_SUSP_PROG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog6 <= 1'b0;
         tog2 <= 1'b0;
      end else if (rd_end) begin
         if (active_op)              tog6 <= ~tog6;
         if (sector_op && in_sector) tog2 <= ~tog2;
      end
   end

endmodule

// File: rtl/fsc_rd_mux.sv
module fsc_rd_mux
   import fsc_pkg::*;
#(
   parameter logic [7:0] ARRAY_FILL = 8'hFF
) (
   input  logic       oe_n,
   input  op_state_e  op_state,
   input  logic       in_sector,
   input  logic       on_pg_byte,
   input  logic       tog6,
   input  logic       tog2,
   output logic [7:0] dout
);

   always_comb begin
      dout = '0;
      if (!oe_n) begin
         case (op_state)
            OP_READ:      dout = ARRAY_FILL;
            OP_PROG:      dout = status_byte(tog6, 1'b1);
            OP_ERASE:     dout = status_byte(tog6, tog2);
            OP_SUSP:      dout = in_sector ? status_byte(tog6, tog2) : ARRAY_FILL;
            OP_SUSP_PROG: dout = status_byte(tog6, on_pg_byte ? 1'b1 :
                                                   (in_sector ? tog2 : 1'b1));
            default:      dout = '0;
         endcase
      end
   end

endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
   import fsc_pkg::*;
#(
   parameter int                ADDR_W     = 18,
   parameter int                SEC_W      = 3,
   parameter logic [ADDR_W-1:0] KEY1_ADDR  = 'h555,
   parameter logic [ADDR_W-1:0] KEY2_ADDR  = 'h2AA,
   parameter int                PROG_LEN   = 64,
   parameter int                ERASE_LEN  = 1024,
   parameter logic [7:0]        ARRAY_FILL = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   output logic [7:0]        dout,
   output wire               ryby_n
);

   if (SEC_W < 1 || SEC_W >= ADDR_W) begin : g_bad_sec
      $error("SEC_W must lie between 1 and ADDR_W-1");
   end
   if (PROG_LEN < 2 || ERASE_LEN < 2) begin : g_bad_len
      $error("operation lengths must be at least 2 cycles");
   end
   if (KEY1_ADDR == KEY2_ADDR) begin : g_bad_key
      $error("unlock addresses must differ");
   end

   op_state_e         op_q;
   cmd_evt_t          evt;
   logic [1:0]        rise;
   logic              wr_stb, rd_end;
   logic              prog_done, erase_done;
   logic [SEC_W-1:0]  ers_sec_q;
   logic [ADDR_W-1:0] pg_addr_q;
   logic              in_sector, on_pg_byte;
   logic              tog6, tog2;
   logic              ry_low;

   fsc_strobe_edge #(.N(2)) u_edge (
      .clk(clk), .rst_n(rst_n), .strobe_n({oe_n, we_n}), .rise(rise)
   );
   assign wr_stb = rise[0];
   assign rd_end = rise[1];

   fsc_cmd_seq #(.ADDR_W(ADDR_W), .KEY1_ADDR(KEY1_ADDR), .KEY2_ADDR(KEY2_ADDR)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(addr), .wr_data(din),
      .op_state(op_q), .evt(evt)
   );

   fsc_op_timer #(.LEN(PROG_LEN)) u_prog_tmr (
      .clk(clk), .rst_n(rst_n), .load(evt.prog),
      .run(op_q == OP_PROG || op_q == OP_SUSP_PROG), .done(prog_done)
   );

   fsc_op_timer #(.LEN(ERASE_LEN)) u_erase_tmr (
      .clk(clk), .rst_n(rst_n), .load(evt.erase),
      .run(op_q == OP_ERASE), .done(erase_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q      <= OP_READ;
         ers_sec_q <= '0;
         pg_addr_q <= '0;
      end else begin
         if (evt.erase) ers_sec_q <= addr[ADDR_W-1 -: SEC_W];
         if (evt.prog)  pg_addr_q <= addr;
         case (op_q)
            OP_READ: begin
               if (evt.prog)       op_q <= OP_PROG;
               else if (evt.erase) op_q <= OP_ERASE;
            end
            OP_PROG:      if (prog_done) op_q <= OP_READ;
            OP_ERASE: begin
               if (erase_done)       op_q <= OP_READ;
               else if (evt.suspend) op_q <= OP_SUSP;
            end
            OP_SUSP: begin
               if (evt.resume)     op_q <= OP_ERASE;
               else if (evt.prog)  op_q <= OP_SUSP_PROG;
            end
            OP_SUSP_PROG: if (prog_done) op_q <= OP_SUSP;
            default:      op_q <= OP_READ;
         endcase
      end
   end

   assign in_sector  = (addr[ADDR_W-1 -: SEC_W] == ers_sec_q);
   assign on_pg_byte = (addr == pg_addr_q);

   fsc_toggle_reg u_tog (
      .clk(clk), .rst_n(rst_n), .rd_end(rd_end), .op_state(op_q),
      .in_sector(in_sector), .tog6(tog6), .tog2(tog2)
   );

   fsc_rd_mux #(.ARRAY_FILL(ARRAY_FILL)) u_rd (
      .oe_n(oe_n), .op_state(op_q), .in_sector(in_sector), .on_pg_byte(on_pg_byte),
      .tog6(tog6), .tog2(tog2), .dout(dout)
   );

   assign ry_low = !rst_n || (op_q == OP_PROG) || (op_q == OP_ERASE) ||
                   (op_q == OP_SUSP_PROG);
   assign ryby_n = ry_low ? 1'b0 : 1'bz;

endmodule

// File: rtl/flash_op_status_chk.sv
module flash_op_status_chk
   import fsc_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      ry_low,
   input op_state_e op_q,
   input logic      tog6,
   input logic      tog2,
   input logic      rd_end,
   input logic      in_sector
);

   a_r6_prog_exit_read: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_q) == OP_PROG && op_q != OP_PROG) |-> op_q == OP_READ);

   a_r12_susp_prog_back: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_q) == OP_SUSP_PROG && op_q != OP_SUSP_PROG) |-> op_q == OP_SUSP);

   a_r3_erase_exit: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_q) == OP_ERASE && op_q != OP_ERASE) |-> (op_q == OP_READ || op_q == OP_SUSP));

   a_r4_suspend_releases: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_q) == OP_ERASE && op_q == OP_SUSP) |-> !ry_low);

   a_r9_susp_holds_dq6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_SUSP && $past(op_q) == OP_SUSP) |-> $stable(tog6));

   a_r8_read_holds_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_READ && $past(op_q) == OP_READ) |-> ($stable(tog6) && $stable(tog2)));

   a_r10_dq2_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_ERASE && rd_end && !in_sector) |=> $stable(tog2));

endmodule

bind flash_op_status flash_op_status_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ry_low(ry_low), .op_q(op_q),
   .tog6(tog6), .tog2(tog2), .rd_end(rd_end), .in_sector(in_sector)
);

// File: tb/flash_op_status_tb.sv
module flash_op_status_tb;

   localparam int AW = 18;
   localparam int PLEN = 80;
   localparam int ELEN = 600;
   localparam logic [AW-1:0] K1 = 18'h00555;
   localparam logic [AW-1:0] K2 = 18'h002AA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          we_n = 1'b1;
   logic          oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [7:0]    din = '0;
   logic [7:0]    dout;
   wire           ryby_n;

   pullup (ryby_n);

   always #5 clk = ~clk;

   flash_op_status #(.ADDR_W(AW), .SEC_W(3), .KEY1_ADDR(K1), .KEY2_ADDR(K2),
                     .PROG_LEN(PLEN), .ERASE_LEN(ELEN)) u_dut (
      .clk(clk), .rst_n(rst_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
      .din(din), .dout(dout), .ryby_n(ryby_n)
   );

   typedef struct {
      string      tag;
      bit         is_ry;
      logic [7:0] exp;
   } item_t;

   item_t q[$];
   event  smp_ev;
   int    checks = 0;
   int    errors = 0;
   bit    m6 = 1'b0;
   bit    m2 = 1'b0;

   function automatic logic [7:0] sb(input bit t6, input bit t2);
      return {1'b0, t6, 3'b000, t2, 2'b00};
   endfunction

   // monitor: pops expected items and compares them with the ports
   initial forever begin
      @(smp_ev);
      while (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         checks++;
         if (it.is_ry) begin
            if (ryby_n !== it.exp[0]) begin
               errors++;
               $display("FAIL %s: ryby_n=%b expected %b", it.tag, ryby_n, it.exp[0]);
            end
         end else if (dout !== it.exp) begin
            errors++;
            $display("FAIL %s: dout=%02h expected %02h", it.tag, dout, it.exp);
         end
      end
   end

   task automatic chk_ry(input string tag, input bit exp_ready);
      item_t it;
      it.tag = tag; it.is_ry = 1'b1; it.exp = {7'b0, exp_ready};
      q.push_back(it);
      -> smp_ev;
      #1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; din = d; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
      item_t it;
      @(negedge clk); addr = a; oe_n = 1'b0;
      @(negedge clk);
      it.tag = tag; it.is_ry = 1'b0; it.exp = exp;
      q.push_back(it);
      -> smp_ev;
      #1;
      oe_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wait_ready(input int limit, input string tag);
      int n;
      n = 0;
      while (ryby_n === 1'b0 && n < limit) begin
         @(negedge clk);
         n++;
      end
      chk_ry(tag, 1'b1);
   endtask

   task automatic unlock();
      wr(K1, 8'hAA);
      wr(K2, 8'h55);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R5: busy held while reset is asserted
      repeat (3) @(negedge clk);
      chk_ry("R5 busy during reset", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_ry("R13 released line pulled high", 1'b1);
      rd(18'h00000, 8'hFF, "R8 read mode fill");

      // R1 / R6: program timing
      unlock();
      wr(K1, 8'hA0);
      chk_ry("R1 not busy after third write", 1'b1);
      wr(18'h00100, 8'h12);
      chk_ry("R1 busy after fourth write", 1'b0);
      repeat (PLEN - 1) @(negedge clk);
      chk_ry("R6 busy through last program cycle", 1'b0);
      @(negedge clk);
      chk_ry("R6 released after program", 1'b1);
      rd(18'h00100, 8'hFF, "R6 read mode after program");

      // R9 / R3: program with status reads and an ignored erase sequence
      unlock(); wr(K1, 8'hA0); wr(18'h00200, 8'h34);
      rd(18'h00200, sb(m6, 1'b1), "R9 program status first");  m6 = ~m6;
      rd(18'h00200, sb(m6, 1'b1), "R9 dq6 flips in program"); m6 = ~m6;
      unlock(); wr(K1, 8'h80); unlock(); wr(18'h10000, 8'h30);
      wait_ready(4 * PLEN, "R3 program ends despite erase writes");
      rd(18'h10000, 8'hFF, "R3 erase ignored while busy");

      // R2 / R10: erase of sector 2
      unlock(); wr(K1, 8'h80); wr(K1, 8'hAA); wr(K2, 8'h55);
      chk_ry("R2 not busy after fifth write", 1'b1);
      wr(18'h10000, 8'h30);
      chk_ry("R2 busy after sixth write", 1'b0);
      rd(18'h10004, sb(m6, m2), "R10 erasing sector first"); m6 = ~m6; m2 = ~m2;
      rd(18'h10008, sb(m6, m2), "R10 dq2 flips in sector"); m6 = ~m6; m2 = ~m2;
      rd(18'h28000, sb(m6, m2), "R10 outside sector");      m6 = ~m6;
      rd(18'h30000, sb(m6, m2), "R10 dq2 held outside, R9 dq6 flips"); m6 = ~m6;
      unlock(); wr(K1, 8'hA0); wr(18'h28010, 8'h55);
      rd(18'h28010, sb(m6, m2), "R3 program ignored during erase"); m6 = ~m6;

      // R4 / R11: suspend
      wr(18'h00000, 8'hB0);
      chk_ry("R4 suspend releases line", 1'b1);
      rd(18'h10000, sb(m6, m2), "R11 suspended sector status"); m2 = ~m2;
      rd(18'h10000, sb(m6, m2), "R9 dq6 held in suspend-read"); m2 = ~m2;
      rd(18'h28000, 8'hFF, "R11 other sector reads fill");

      // R12: program inside the suspend
      unlock(); wr(K1, 8'hA0); wr(18'h28010, 8'h5A);
      chk_ry("R12 suspend-program busy", 1'b0);
      rd(18'h28010, sb(m6, 1'b1), "R12 programmed byte dq2 one"); m6 = ~m6;
      rd(18'h10000, sb(m6, m2), "R12 suspended sector dq2");      m6 = ~m6; m2 = ~m2;
      rd(18'h30000, sb(m6, 1'b1), "R12 other address dq2 one");   m6 = ~m6;
      wait_ready(4 * PLEN, "R12 suspend-program completes");
      rd(18'h10000, sb(m6, m2), "R12 back in suspend-read"); m2 = ~m2;

      // R4 / R6: resume and finish the erase
      wr(18'h00000, 8'h30);
      chk_ry("R4 resume drives busy", 1'b0);
      wait_ready(2 * ELEN, "R6 erase completes");
      rd(18'h10000, 8'hFF, "R6 read mode after erase");

      // R7: broken sequences
      wr(K1, 8'hAA); wr(18'h00123, 8'h55); wr(K1, 8'hA0); wr(18'h00400, 8'h11);
      chk_ry("R7 wrong address starts nothing", 1'b1);
      wr(K1, 8'hAA); wr(K2, 8'h54); wr(K1, 8'hA0); wr(18'h00400, 8'h11);
      chk_ry("R7 wrong data starts nothing", 1'b1);
      unlock(); wr(K1, 8'h80); unlock(); wr(18'h10000, 8'h31);
      chk_ry("R7 wrong final erase code", 1'b1);
      rd(18'h10000, 8'hFF, "R7 still read mode");

      // R5: reset aborts an erase
      unlock(); wr(K1, 8'h80); unlock(); wr(18'h18000, 8'h30);
      chk_ry("R5 erase started", 1'b0);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk_ry("R5 busy while reset held", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_ry("R5 released after reset", 1'b1);
      m6 = 1'b0; m2 = 1'b0;
      rd(18'h18000, 8'hFF, "R5 read mode after reset");

      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule